// File: doc/BRIEF.md
# Fixed-Point Divide / Square-Root / Reciprocal-Root Unit

This block is an iterative arithmetic unit for unsigned fixed-point numbers. One datapath computes any of three results: an unsigned quotient with remainder, a square root with remainder, or a reciprocal square root with remainder. The caller picks the result with a 2-bit operation code. An operand pair is handed over through a valid/ready handshake. The unit then runs a digit recurrence, most significant digit first, and settles `LOG2_RADIX` result bits in each step. The result waits on a valid/ready output handshake until it is taken.

Internally the unit keeps a comparison target, which is the left-hand side of the equation being solved. At start it loads this target from the operation, the dividend and the divisor/radicand, and it clears the partial result, the running product and the committed right-hand side. In each step every nonzero value of the next digit is tried in parallel. The right-hand side is evaluated for each trial, and the largest trial that does not exceed the target is kept. The remainder is the target minus the final right-hand side.

The result is `BW` bits wide with `FW` fraction bits. The divisor/radicand has the same format. The dividend is `BW+FW` bits wide with `2*FW` fraction bits. The remainder is `3*BW` bits wide with `3*FW` fraction bits. Operation code 3 is not supported.

Top module: `fxp_divsqrt_unit`

## Requirements
- R1: With op code 0, the result q is the largest value below 2^BW with q*d <= dividend, where q, d and the dividend are read as plain integers. The remainder is (dividend - q*d) << FW.
- R2: With op code 1, q is the largest value with q*q <= radicand << FW. The remainder is (radicand << 2*FW) - ((q*q) << FW).
- R3: With op code 2, q is the largest value below 2^BW with q*q*radicand <= 2^(3*FW). The remainder is 2^(3*FW) - q*q*radicand.
- R4: A zero divisor (op code 0) or a zero radicand (op code 2) gives an all-ones q, and the remainder is the full left-hand side. A division whose true quotient needs more than BW bits also gives an all-ones q. No result bit beyond BW is ever set.
- R5: out_valid goes high at the ceil(BW/LOG2_RADIX)-th rising edge after the edge that accepted the operands. When BW is not a multiple of LOG2_RADIX, the first step settles only the leftover high bits.
- R6: in_ready is high only while the unit is idle. Operands are taken at an edge where in_valid and in_ready are both high. Values on the input ports while busy have no effect on the result.
- R7: While out_valid is high and out_ready is low, out_valid, out_qroot and out_rem stay unchanged.
- R8: After an edge where out_valid and out_ready are both high, out_valid is low and in_ready is high.
- R9: Reset is synchronous and active high. After reset, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op code are present |
| in_ready | output | 1 | Unit is idle and will take operands |
| in_op | input | 2 | 0 divide, 1 square root, 2 reciprocal square root |
| in_dividend | input | BW+FW | Dividend, 2*FW fraction bits |
| in_divrad | input | BW | Divisor or radicand, FW fraction bits |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_qroot | output | BW | Quotient or root, FW fraction bits |
| out_rem | output | 3*BW | Remainder, 3*FW fraction bits |

## Verification
A wrong digit choice in any step leaves a wrong quotient or root. Because the remainder is taken against the last right-hand side, the same error also shows as a wrong or oversized remainder, and the bench checks both on the first cycle out_valid is high. An error in the step counter or the state register shows at once as out_valid or in_ready in the wrong cycle, since the bench model predicts both ports on every clock. Corrupted operands while busy show up as a wrong result at the end of that operation.

// File: rtl/fxp_ds_pkg.sv
package fxp_ds_pkg;

  typedef enum logic [1:0] {
    OP_DIV   = 2'd0,
    OP_SQRT  = 2'd1,
    OP_RSQRT = 2'd2
  } ds_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ds_state_e;

endpackage

// File: rtl/fxp_ds_setup.sv
// Loads the comparison target (left-hand side) from the operation.
module fxp_ds_setup
  import fxp_ds_pkg::*;
#(
  parameter int BW = 8,
  parameter int FW = 4
) (
  input  ds_op_e              op,
  input  logic [BW+FW-1:0]    dividend,
  input  logic [BW-1:0]       divrad,
  output logic [3*BW-1:0]     lhs
);
  localparam int LW = 3 * BW;

  always_comb begin
    case (op)
      OP_DIV:  lhs = LW'(dividend) << FW;
      OP_SQRT: lhs = LW'(divrad) << (2 * FW);
      default: lhs = LW'(1) << (3 * FW);
    endcase
  end
endmodule

// File: rtl/fxp_ds_cand.sv
// Evaluates one trial digit value against the comparison target.
module fxp_ds_cand
  import fxp_ds_pkg::*;
#(
  parameter int BW    = 8,
  parameter int FW    = 4,
  parameter int RBITS = 3,
  parameter int DIGIT = 1,
  parameter int SW    = 4
) (
  input  ds_op_e            op,
  input  logic [BW-1:0]     q_cur,
  input  logic [2*BW-1:0]   qd_cur,
  input  logic [BW-1:0]     divrad,
  input  logic [3*BW-1:0]   lhs,
  input  logic [SW-1:0]     shamt,
  output logic              fit,
  output logic [BW-1:0]     q_try,
  output logic [2*BW-1:0]   qd_try,
  output logic [3*BW-1:0]   rhs_try
);
  localparam int WW = 3 * BW + RBITS;

  logic [WW-1:0] inc_w, q_w, qd_w, rhs_w;
  logic          over_q, over_qd;

  always_comb begin
    inc_w = WW'(DIGIT) << shamt;
    q_w   = WW'(q_cur) | inc_w;
    qd_w  = WW'(qd_cur) + inc_w * WW'(divrad);
    case (op)
      OP_DIV:  rhs_w = qd_w << FW;
      OP_SQRT: rhs_w = (q_w * q_w) << FW;
      default: rhs_w = q_w * qd_w;
    endcase
    over_q  = |q_w[WW-1:BW];
    over_qd = |qd_w[WW-1:2*BW];
    fit     = !over_q && !over_qd && (rhs_w <= WW'(lhs));
  end

  assign q_try   = q_w[BW-1:0];
  assign qd_try  = qd_w[2*BW-1:0];
  assign rhs_try = rhs_w[3*BW-1:0];
endmodule

// File: rtl/fxp_ds_pick.sv
// Chooses the largest fitting trial digit, zero when none fits.
module fxp_ds_pick #(
  parameter int RBITS = 3,
  parameter int NC    = 7
) (
  input  logic [NC-1:0]    fit,
  output logic [RBITS-1:0] digit
);
  always_comb begin
    digit = '0;
    for (int i = 0; i < NC; i++) begin
      if (fit[i]) digit = RBITS'(i + 1);
    end
  end
endmodule

// File: rtl/fxp_divsqrt_unit.sv
module fxp_divsqrt_unit
  import fxp_ds_pkg::*;
#(
  parameter int BW         = 8,
  parameter int FW         = 4,
  parameter int LOG2_RADIX = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           in_op,
  input  logic [BW+FW-1:0]     in_dividend,
  input  logic [BW-1:0]        in_divrad,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [BW-1:0]        out_qroot,
  output logic [3*BW-1:0]      out_rem
);
  localparam int NC  = (1 << LOG2_RADIX) - 1;
  localparam int NIT = (BW + LOG2_RADIX - 1) / LOG2_RADIX;
  localparam int CW  = $clog2(NIT + 1);
  localparam int SW  = $clog2(NIT * LOG2_RADIX + 1);
  localparam int LW  = 3 * BW;

  ds_state_e           state;
  ds_op_e              op_r;
  logic [CW-1:0]       cnt;
  logic [BW-1:0]       d_r, q_r;
  logic [2*BW-1:0]     qd_r;
  logic [LW-1:0]       lhs_r, rhs_r, rem_r;
  logic [LW-1:0]       lhs_init;
  logic [SW-1:0]       shamt;

  logic [NC-1:0]       fit_vec;
  logic [BW-1:0]       cq   [NC];
  logic [2*BW-1:0]     cqd  [NC];
  logic [LW-1:0]       crhs [NC];
  logic [LOG2_RADIX-1:0] digit;

  logic [BW-1:0]       q_next;
  logic [2*BW-1:0]     qd_next;
  logic [LW-1:0]       rhs_next;

  fxp_ds_setup #(.BW(BW), .FW(FW)) u_setup (
    .op       (ds_op_e'(in_op)),
    .dividend (in_dividend),
    .divrad   (in_divrad),
    .lhs      (lhs_init)
  );

  assign shamt = SW'(cnt) * SW'(LOG2_RADIX);

  for (genvar g = 0; g < NC; g++) begin : g_cand
    fxp_ds_cand #(
      .BW(BW), .FW(FW), .RBITS(LOG2_RADIX), .DIGIT(g + 1), .SW(SW)
    ) u_cand (
      .op      (op_r),
      .q_cur   (q_r),
      .qd_cur  (qd_r),
      .divrad  (d_r),
      .lhs     (lhs_r),
      .shamt   (shamt),
      .fit     (fit_vec[g]),
      .q_try   (cq[g]),
      .qd_try  (cqd[g]),
      .rhs_try (crhs[g])
    );
  end

  fxp_ds_pick #(.RBITS(LOG2_RADIX), .NC(NC)) u_pick (
    .fit   (fit_vec),
    .digit (digit)
  );

  always_comb begin
    q_next   = q_r;
    qd_next  = qd_r;
    rhs_next = rhs_r;
    for (int i = 0; i < NC; i++) begin
      if (digit == LOG2_RADIX'(i + 1)) begin
        q_next   = cq[i];
        qd_next  = cqd[i];
        rhs_next = crhs[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            state <= ST_RUN;
            cnt   <= CW'(NIT - 1);
            op_r  <= ds_op_e'(in_op);
            d_r   <= in_divrad;
            lhs_r <= lhs_init;
            q_r   <= '0;
            qd_r  <= '0;
            rhs_r <= '0;
          end
        end
        ST_RUN: begin
          q_r   <= q_next;
          qd_r  <= qd_next;
          rhs_r <= rhs_next;
          if (cnt == '0) begin
            state <= ST_DONE;
            rem_r <= lhs_r - rhs_next;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_DONE: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign out_qroot = q_r;
  assign out_rem   = rem_r;

  // ---------------- assertions ----------------
  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else if (in_valid && in_ready) run_len <= '0;
    else if (state == ST_RUN) run_len <= run_len + 1'b1;
  end

  // R5: steps between accept and result equal ceil(BW/LOG2_RADIX)
  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (run_len == (CW+1)'(NIT)));

  // R1 R2 R3: committed right-hand side never passes the target
  assert_rhs_bound_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (rhs_r <= lhs_r));

  // R2: trial fits form a run from the smallest digit upward
  assert_fit_thermo_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> ((fit_vec & (fit_vec + 1'b1)) == '0));

  // R6: accept makes the unit busy
  assert_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R7: held result does not change
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_qroot) && $stable(out_rem)));

  // R8: output handshake returns to idle
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  // R6 R8: never idle and holding a result together
  assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));
endmodule

// File: tb/fxp_divsqrt_unit_bench.sv
`timescale 1ns/1ps
module fxp_divsqrt_unit_bench;
  localparam int BW  = 8;
  localparam int FW  = 4;
  localparam int RB  = 3;
  localparam int NIT = (BW + RB - 1) / RB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [1:0] in_op = 2'd0;
  logic [BW+FW-1:0] in_dividend = '0;
  logic [BW-1:0] in_divrad = '0;
  logic in_ready, out_valid;
  logic [BW-1:0] out_qroot;
  logic [3*BW-1:0] out_rem;

  always #4 clk = ~clk;

  fxp_divsqrt_unit #(.BW(BW), .FW(FW), .LOG2_RADIX(RB)) u_fxp_divsqrt_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dividend(in_dividend), .in_divrad(in_divrad),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_qroot(out_qroot), .out_rem(out_rem)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int cyc = 0;

  // behavioural model state
  int m_st = 0;     // 0 idle, 1 busy, 2 result held
  int m_left = 0;
  longint m_q = 0, m_rem = 0;
  string m_tag = "R1";
  string q_tag = "R1";

  function automatic longint lhs_of(int op, longint a, longint d);
    if (op == 0) return a << FW;
    if (op == 1) return d << (2 * FW);
    return longint'(1) << (3 * FW);
  endfunction

  function automatic longint rhs_of(int op, longint q, longint d);
    if (op == 0) return (q * d) << FW;
    if (op == 1) return (q * q) << FW;
    return q * q * d;
  endfunction

  function automatic longint best_q(int op, longint a, longint d);
    longint b = 0;
    for (longint q = 0; q < (longint'(1) << BW); q++)
      if (rhs_of(op, q, d) <= lhs_of(op, a, d)) b = q;
    return b;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one clock: compare outputs with model, advance model with current inputs
  task automatic step();
    chk(in_ready == (m_st == 0), "R6", in_ready, m_st == 0);
    chk(out_valid == (m_st == 2), "R5", out_valid, m_st == 2);
    if (m_st == 2 && out_valid) begin
      chk(out_qroot == BW'(m_q), q_tag, out_qroot, m_q);
      chk(out_rem == (3*BW)'(m_rem), q_tag, out_rem, m_rem);
    end
    case (m_st)
      0: if (in_valid) begin
           m_st = 1;
           m_left = NIT - 1;
           m_q = best_q(int'(in_op), longint'(in_dividend), longint'(in_divrad));
           m_rem = lhs_of(int'(in_op), longint'(in_dividend), longint'(in_divrad))
                   - rhs_of(int'(in_op), m_q, longint'(in_divrad));
         end
      1: if (m_left == 0) m_st = 2; else m_left--;
      default: if (out_ready) m_st = 0;
    endcase
    @(negedge clk);
  endtask

  task automatic run_op(int op, longint a, longint d, int hold, string tag);
    in_valid = 1'b1;
    in_op = 2'(op);
    in_dividend = (BW+FW)'(a);
    in_divrad = BW'(d);
    out_ready = 1'b0;
    m_tag = tag;
    q_tag = tag;
    do step(); while (m_st == 0);
    // R6: junk on the inputs while busy must not alter the result
    in_dividend = ~in_dividend;
    in_divrad = ~in_divrad;
    in_op = 2'(op == 0 ? 1 : 0);
    while (m_st == 1) step();
    in_valid = 1'b0;
    for (int i = 0; i < hold; i++) begin
      q_tag = (i == 0) ? tag : "R7";
      step();
    end
    q_tag = tag;
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
    // R8: idle right after the output handshake
    chk(in_ready && !out_valid, "R8", {in_ready, out_valid}, 2'b10);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual %0d expected %0d", cyc, 20000);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: state right after reset
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9", {in_ready, out_valid}, 2'b10);

    // R1 division
    run_op(0, 12'h9A3, 8'h15, 1, "R1");
    run_op(0, 12'h0F0, 8'h30, 3, "R1");
    run_op(0, 12'h001, 8'hFF, 0, "R1");
    // R2 square root
    run_op(1, 0, 8'h10, 2, "R2");
    run_op(1, 0, 8'h40, 0, "R2");
    run_op(1, 0, 8'hFF, 1, "R2");
    run_op(1, 0, 8'h00, 0, "R2");
    run_op(1, 0, 8'h03, 0, "R2");
    // R3 reciprocal square root
    run_op(2, 0, 8'h10, 0, "R3");
    run_op(2, 0, 8'h40, 2, "R3");
    run_op(2, 0, 8'h03, 0, "R3");
    run_op(2, 0, 8'hFF, 0, "R3");
    // R4 degenerate operands and quotient overflow
    run_op(0, 12'h5A5, 8'h00, 1, "R4");
    run_op(2, 0, 8'h00, 0, "R4");
    run_op(0, 12'hFFF, 8'h01, 0, "R4");
    // back-to-back traffic with in_valid raised right after release
    for (int k = 1; k < 6; k++) run_op(k % 3, 12'h123 * k, 8'h11 * k, k % 2, "R5");

    repeat (2) step();
    summary();
  end
endmodule